// File: doc/BRIEF.md
# Prioritized Trap Controller

This block folds sixteen level-sensitive interrupt lines and ten synchronous exception requests into one trap request for a processor core. Each request carries a five-bit cause code and the address where the handler starts. The block also holds the status-word fields that trap handling touches: a per-line interrupt mask, a stack of three mode/interrupt-enable pairs (current, previous, old), a vector-base select bit and the last cause.

The core sees `trap_req`, `trap_cause` and `trap_vector` as combinational outputs. The core accepts the trap by raising `trap_ack` in a cycle where `trap_req` is high. At that clock edge the mode/enable stack shifts, the core enters kernel mode with interrupts off, and the cause is recorded. A return-from-exception strobe pops the stack. If the strobe arrives in user mode it becomes a privileged-instruction exception. Software reads the status word on `psw_rdata` and writes it through `psw_we`/`psw_wdata`.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the status word reads 0: kernel mode (mode bit 0 = kernel, 1 = user), interrupts disabled, ROM vector base, cause 0, mask 0. With no exception request, `trap_req` is low.
- R2: An interrupt line raises a request only while its input is high, its mask bit (status bits 15:0) is set and the current interrupt-enable bit (status bit 21) is set. Nothing is latched: when the line drops, the request is gone.
- R3: Among requesting interrupt lines, the highest-numbered line wins, and its cause code equals the line number (0..15).
- R4: `exc_req[i]` raises exception cause 16+i (16 bus timeout, 17 illegal instruction, 18 privileged instruction, 19 divide, 20 trap, 21 TLB miss, 22 TLB write, 23 TLB invalid, 24 illegal address, 25 privileged address). Any exception wins over any interrupt, and the lowest exception code wins among exceptions.
- R5: The general entry point is base + 4. The base is ROM_BASE when status bit 27 is 0 and RAM_BASE when it is 1.
- R6: A TLB miss (cause 21) with `fault_va_msb` = 0 enters at base + 0. A TLB miss with `fault_va_msb` = 1 uses base + 4.
- R7: When `trap_ack` is high while `trap_req` is high, at the clock edge: old pair (bits 26 mode, 25 enable) ← previous pair (24, 23), previous ← current (22, 21), current ← kernel with interrupts off, and cause (bits 20:16) ← `trap_cause`. Mask and vector bit are unchanged.
- R8: A `rfe_req` strobe in kernel mode, with no trap taken, sets current ← previous and previous ← old, and leaves old unchanged.
- R9: `rfe_req` in user mode does not change the stack. It raises `trap_req` with cause 18.
- R10: A `psw_we` write loads bits 27:0, and bits 31:28 read 0. A `trap_ack` with no pending request has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Level interrupt inputs, line 15 highest |
| exc_req | input | 10 | Synchronous exception requests, bit i is cause 16+i |
| fault_va_msb | input | 1 | Bit 31 of the faulting virtual address |
| trap_ack | input | 1 | Core accepts the presented trap |
| rfe_req | input | 1 | Return-from-exception strobe |
| psw_we | input | 1 | Status word write enable |
| psw_wdata | input | 32 | Status word write data |
| trap_req | output | 1 | A trap is pending |
| trap_cause | output | 5 | Cause code of the pending trap |
| trap_vector | output | 32 | Handler entry address |
| psw_rdata | output | 32 | Status word |

## Verification
The bench drives masked-off lines and an interrupt-enable of zero while lines are high. A design that latched or ignored the mask would trap there. It also drops a line to show that a level-only design leaves nothing pending.

Several lines are raised at once, and exceptions are raised alongside interrupts. An inverted priority encoder would report line 0 or an interrupt cause instead of the winner.

Both senses of the address bit are tried on a TLB miss under both vector bases. This exposes a swapped offset or a dead base select.

A trap is taken, then undone by a return-from-exception, starting from a stack where every pair differs. Shifting in the wrong direction or clearing the old pair shows up as a wrong status word. A return attempted from user mode must trap with cause 18 and leave the stack alone until the trap is accepted.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int N_IRQ     = 16;
    localparam int N_EXC     = 10;
    localparam int CAUSE_W   = 5;
    localparam int EXC_BASE  = 16;
    localparam int TLB_MISS  = 21;
    localparam int PRIV_INST = 18;
    localparam int XLEN      = 32;

    typedef struct packed {
        logic               vec_ram;
        logic               old_user;
        logic               old_ie;
        logic               prev_user;
        logic               prev_ie;
        logic               cur_user;
        logic               cur_ie;
        logic [CAUSE_W-1:0] cause;
        logic [N_IRQ-1:0]   mask;
    } psw_t;

    localparam int PSW_W = $bits(psw_t);
endpackage

// File: rtl/trap_irq_arb.sv
module trap_irq_arb #(
    parameter int LINES = 16,
    localparam int IW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend,
    output logic             hit,
    output logic [IW-1:0]    sel
);
    // ascending scan: the last set bit seen is the highest line
    always_comb begin
        hit = |pend;
        sel = '0;
        for (int i = 0; i < LINES; i++) begin
            if (pend[i]) sel = IW'(i);
        end
    end

    // R3
    line_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pend[sel] && ((pend >> sel) == LINES'(1))));
endmodule

// File: rtl/trap_exc_arb.sv
module trap_exc_arb #(
    parameter int LINES  = 10,
    parameter int CODE_W = 5,
    parameter int BASE   = 16,
    localparam int IW = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  req,
    output logic              hit,
    output logic [CODE_W-1:0] code
);
    logic [IW-1:0] sel;

    // descending scan: the last set bit seen is the lowest code
    always_comb begin
        hit = |req;
        sel = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req[i]) sel = IW'(i);
        end
        code = CODE_W'(BASE) + CODE_W'(sel);
    end

    // R4
    low_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req[sel] && ((req & ((LINES'(1) << sel) - LINES'(1))) == '0)));
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
    parameter int          XLEN     = 32,
    parameter logic [31:0] ROM_BASE = 32'hE000_0000,
    parameter logic [31:0] RAM_BASE = 32'hC000_0000,
    parameter int          GEN_OFS  = 4
) (
    input  logic            use_ram,
    input  logic            short_entry,
    output logic [XLEN-1:0] vector
);
    logic [XLEN-1:0] base;

    always_comb begin
        base   = use_ram ? XLEN'(RAM_BASE) : XLEN'(ROM_BASE);
        vector = base + (short_entry ? XLEN'(0) : XLEN'(GEN_OFS));
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter logic [31:0] ROM_BASE = 32'hE000_0000,
    parameter logic [31:0] RAM_BASE = 32'hC000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_IRQ-1:0]    irq_lines,
    input  logic [N_EXC-1:0]    exc_req,
    input  logic                fault_va_msb,
    input  logic                trap_ack,
    input  logic                rfe_req,
    input  logic                psw_we,
    input  logic [XLEN-1:0]     psw_wdata,
    output logic                trap_req,
    output logic [CAUSE_W-1:0]  trap_cause,
    output logic [XLEN-1:0]     trap_vector,
    output logic [XLEN-1:0]     psw_rdata
);
    localparam int IRQ_IW = $clog2(N_IRQ);

    psw_t               psw_d, psw_q;
    logic [N_IRQ-1:0]   pend;
    logic [N_EXC-1:0]   exc_all;
    logic               rfe_user;
    logic               irq_hit, exc_hit, take, short_entry;
    logic [IRQ_IW-1:0]  irq_sel;
    logic [CAUSE_W-1:0] exc_code;

    always_comb begin
        pend     = irq_lines & psw_q.mask & {N_IRQ{psw_q.cur_ie}};
        rfe_user = rfe_req & psw_q.cur_user;
        exc_all  = exc_req;
        exc_all[PRIV_INST-EXC_BASE] = exc_req[PRIV_INST-EXC_BASE] | rfe_user;
    end

    trap_irq_arb #(.LINES(N_IRQ)) i_irq_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .hit(irq_hit), .sel(irq_sel)
    );

    trap_exc_arb #(.LINES(N_EXC), .CODE_W(CAUSE_W), .BASE(EXC_BASE)) i_exc_arb (
        .clk(clk), .rst_n(rst_n), .req(exc_all), .hit(exc_hit), .code(exc_code)
    );

    always_comb begin
        trap_req    = exc_hit | irq_hit;
        trap_cause  = exc_hit ? exc_code : CAUSE_W'(irq_sel);
        short_entry = exc_hit && (exc_code == CAUSE_W'(TLB_MISS)) && !fault_va_msb;
        take        = trap_req & trap_ack;
    end

    trap_vec_gen #(.XLEN(XLEN), .ROM_BASE(ROM_BASE), .RAM_BASE(RAM_BASE), .GEN_OFS(4)) i_vec_gen (
        .use_ram(psw_q.vec_ram), .short_entry(short_entry), .vector(trap_vector)
    );

    // next-state: trap entry, then return, then software write
    always_comb begin
        psw_d = psw_q;
        if (take) begin
            psw_d.old_user  = psw_q.prev_user;
            psw_d.old_ie    = psw_q.prev_ie;
            psw_d.prev_user = psw_q.cur_user;
            psw_d.prev_ie   = psw_q.cur_ie;
            psw_d.cur_user  = 1'b0;
            psw_d.cur_ie    = 1'b0;
            psw_d.cause     = trap_cause;
        end else if (rfe_req && !psw_q.cur_user) begin
            psw_d.cur_user  = psw_q.prev_user;
            psw_d.cur_ie    = psw_q.prev_ie;
            psw_d.prev_user = psw_q.old_user;
            psw_d.prev_ie   = psw_q.old_ie;
        end else if (psw_we) begin
            psw_d = psw_t'(psw_wdata[PSW_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psw_q <= '0;
        else        psw_q <= psw_d;
    end

    assign psw_rdata = XLEN'(psw_q);

    // R2
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !exc_hit) |-> (psw_q.cur_ie && irq_lines[trap_cause[IRQ_IW-1:0]]));

    // R4
    exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req != '0) |-> (trap_req && trap_cause >= CAUSE_W'(EXC_BASE)));

    // R7
    trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_ack) |=> (!psw_q.cur_ie && !psw_q.cur_user
            && psw_q.prev_ie == $past(psw_q.cur_ie)
            && psw_q.old_user == $past(psw_q.prev_user)
            && psw_q.cause == $past(trap_cause)));

    // R8
    rfe_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_req && !psw_q.cur_user && !(trap_req && trap_ack)) |=>
            (psw_q.cur_user == $past(psw_q.prev_user) && psw_q.cur_ie == $past(psw_q.prev_ie)
             && psw_q.old_ie == $past(psw_q.old_ie)));
endmodule

// File: tb/test_trap_ctrl.sv
module test_trap_ctrl;
    localparam logic [31:0] ROM_B = 32'hE000_0000;
    localparam logic [31:0] RAM_B = 32'hC000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [9:0]  exc_req = '0;
    logic        fault_va_msb = 1'b0;
    logic        trap_ack = 1'b0;
    logic        rfe_req = 1'b0;
    logic        psw_we = 1'b0;
    logic [31:0] psw_wdata = '0;
    logic        trap_req;
    logic [4:0]  trap_cause;
    logic [31:0] trap_vector;
    logic [31:0] psw_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_ctrl #(.ROM_BASE(ROM_B), .RAM_BASE(RAM_B)) i_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .exc_req(exc_req),
        .fault_va_msb(fault_va_msb), .trap_ack(trap_ack), .rfe_req(rfe_req),
        .psw_we(psw_we), .psw_wdata(psw_wdata), .trap_req(trap_req),
        .trap_cause(trap_cause), .trap_vector(trap_vector), .psw_rdata(psw_rdata)
    );

    function automatic logic [31:0] mk(input logic vr, ou, oi, pu, pi, cu, ci,
                                       input logic [4:0] cause, input logic [15:0] mask);
        return {4'b0, vr, ou, oi, pu, pi, cu, ci, cause, mask};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_psw(input logic [31:0] v);
        @(negedge clk); psw_we = 1'b1; psw_wdata = v;
        @(negedge clk); psw_we = 1'b0;
    endtask

    task automatic t_reset;
        irq_lines = 16'hFFFF; #1;
        chk("R1 psw after reset", psw_rdata, 32'h0);
        chk("R1 no request, interrupts off", {31'b0, trap_req}, 32'h0);
        irq_lines = '0;
    endtask

    task automatic t_gating;
        set_psw(mk(0,0,0,0,0,0,1,5'd0,16'h0100));
        @(negedge clk); irq_lines = 16'h0100; #1;
        chk("R2 enabled line requests", {31'b0, trap_req}, 32'h1);
        chk("R2 cause of line 8", {27'b0, trap_cause}, 32'd8);
        @(negedge clk); irq_lines = 16'h0200; #1;
        chk("R2 masked line ignored", {31'b0, trap_req}, 32'h0);
        @(negedge clk); irq_lines = 16'h0000; #1;
        chk("R2 dropped line not latched", {31'b0, trap_req}, 32'h0);
        set_psw(mk(0,0,0,0,0,0,0,5'd0,16'h0100));
        @(negedge clk); irq_lines = 16'h0100; #1;
        chk("R2 global enable off", {31'b0, trap_req}, 32'h0);
        irq_lines = '0;
    endtask

    task automatic t_irq_prio;
        set_psw(mk(0,0,0,0,0,0,1,5'd0,16'hFFFF));
        @(negedge clk); irq_lines = 16'h4101; #1;
        chk("R3 timer line 14 wins", {27'b0, trap_cause}, 32'd14);
        chk("R5 ROM general entry", trap_vector, ROM_B + 32'd4);
        @(negedge clk); irq_lines = 16'h8001; #1;
        chk("R3 line 15 wins", {27'b0, trap_cause}, 32'd15);
        @(negedge clk); irq_lines = 16'h0001; #1;
        chk("R3 lone line 0", {27'b0, trap_cause}, 32'd0);
        irq_lines = '0;
    endtask

    task automatic t_exc_prio;
        @(negedge clk); irq_lines = 16'h8000; exc_req = 10'b00_0000_1000; #1;
        chk("R4 divide over interrupt", {27'b0, trap_cause}, 32'd19);
        @(negedge clk); exc_req = 10'b10_0000_0010; #1;
        chk("R4 lowest exception code", {27'b0, trap_cause}, 32'd17);
        set_psw(mk(1,0,0,0,0,0,1,5'd0,16'hFFFF));
        @(negedge clk); #1;
        chk("R5 RAM general entry", trap_vector, RAM_B + 32'd4);
        exc_req = '0; irq_lines = '0;
    endtask

    task automatic t_tlb_miss;
        @(negedge clk); exc_req = 10'b00_0010_0000; fault_va_msb = 1'b0; #1;
        chk("R6 user miss cause", {27'b0, trap_cause}, 32'd21);
        chk("R6 user miss RAM base+0", trap_vector, RAM_B);
        @(negedge clk); fault_va_msb = 1'b1; #1;
        chk("R6 kernel miss RAM base+4", trap_vector, RAM_B + 32'd4);
        set_psw(mk(0,0,0,0,0,0,1,5'd0,16'hFFFF));
        @(negedge clk); fault_va_msb = 1'b0; #1;
        chk("R6 user miss ROM base+0", trap_vector, ROM_B);
        exc_req = '0;
    endtask

    task automatic t_entry_and_return;
        set_psw(mk(0,0,0,0,1,1,1,5'd0,16'hFFFF));
        @(negedge clk); irq_lines = 16'h4000; trap_ack = 1'b1;
        @(negedge clk); trap_ack = 1'b0; irq_lines = '0; #1;
        chk("R7 stack shift on entry", psw_rdata, mk(0,0,1,1,1,0,0,5'd14,16'hFFFF));
        @(negedge clk); rfe_req = 1'b1;
        @(negedge clk); rfe_req = 1'b0; #1;
        chk("R8 stack pop on return", psw_rdata, mk(0,0,1,0,1,1,1,5'd14,16'hFFFF));
        @(negedge clk); rfe_req = 1'b1; #1;
        chk("R9 user return traps", {31'b0, trap_req}, 32'h1);
        chk("R9 user return cause", {27'b0, trap_cause}, 32'd18);
        @(negedge clk); #1;
        chk("R9 stack untouched", psw_rdata, mk(0,0,1,0,1,1,1,5'd14,16'hFFFF));
        trap_ack = 1'b1;
        @(negedge clk); trap_ack = 1'b0; rfe_req = 1'b0; #1;
        chk("R9 privileged trap taken", psw_rdata, mk(0,0,1,1,1,0,0,5'd18,16'hFFFF));
    endtask

    task automatic t_write;
        set_psw(32'hFFFF_FFFF); #1;
        chk("R10 reserved bits read zero", psw_rdata, 32'h0FFF_FFFF);
        @(negedge clk); trap_ack = 1'b1;
        @(negedge clk); trap_ack = 1'b0; #1;
        chk("R10 stray ack ignored", psw_rdata, 32'h0FFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_gating();
        t_irq_prio();
        t_exc_prio();
        t_tlb_miss();
        t_entry_and_return();
        t_write();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule